// File: doc/BRIEF.md
# Multiplexed Eight-Digit Display Refresh Controller

This block drives a time-multiplexed display of eight digits. A free-running 3-bit scan position steps through the digits one at a time. The same scan lines can also serve a keyboard column scanner. For the digit being scanned, the block presents one byte from an internal display memory as two 4-bit segment halves. The scan lines carry either the binary position (encoded form) or a one-hot select (decoded form).

A host drives a single byte port. Each byte is marked as either a command or a data byte. The top three bits of a command pick its kind. Commands set the scan form, latch a target digit for later data bytes, blank or write-protect either half of the segment output, and wipe the whole display memory. The wipe runs while the digits are being scanned and is reported on a busy output.

Both segment halves are forced to the blank code for a short guard interval at the start of every digit slot. This keeps the previous digit's pattern from ghosting onto the next scan line.

Top module: `disp_refresh_ctrl`

## Requirements
- R1: After reset the scan position is 0 and the scan form is encoded, so `scan_o` = 0. Both segment halves show the blank code (default 4'h0), `busy` is low, no blanking or write inhibit is active, and every display memory byte holds the blank code in both halves.
- R2: The scan position advances by one every DWELL clock cycles (default 16) and wraps from NDIG-1 back to 0. After k clock edges from reset it equals floor(k/DWELL) mod NDIG.
- R3: A mode-set command has the form 000 D D K K K. The two D bits are bits 4:3. When they are 00 the scan form is encoded: `scan_o` = position, zero-extended. Any other value selects the decoded form: `scan_o` = 1 << position. Bits 2:0 of this command have no effect on the display.
- R4: The command kind is taken from bits 7:5 of a command byte. 000 is mode set, 100 is set write address, 101 is inhibit/blank, and 110 is clear. Kinds 001, 010, 011 and 111 change nothing.
- R5: Command 100 latches bits 2:0 as the write address. A later data byte (`host_cmd` = 0) is stored at that address. When that digit is scanned after its guard interval, `seg_hi` = byte[7:4] and `seg_lo` = byte[3:0].
- R6: In command 101, bit 0 forces `seg_lo` to the blank code and bit 1 forces `seg_hi` to the blank code. Stored bytes are kept, so the digits reappear once these bits are cleared.
- R7: In command 101, bit 2 protects the low nibble of every stored byte from data writes and bit 3 protects the high nibble. The unprotected half is still written.
- R8: During the first GUARD cycles of every digit slot (default 2), both segment halves equal the blank code.
- R9: Command 110 raises `busy` on the next cycle. While `busy` is high, every digit is rewritten with the blank code in both halves. `busy` falls once the scan position has advanced NDIG times, which takes at most NDIG*DWELL cycles. Data bytes that arrive while `busy` is high are dropped.
- R10: Commands and data bytes never disturb the scan timing. The position sequence of R2 holds regardless of host traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host byte strobe, one cycle per byte |
| host_cmd | input | 1 | 1: byte is a command, 0: byte is digit data |
| host_byte | input | 8 | Host command or data byte |
| scan_o | output | NDIG (8) | Scan lines, encoded or decoded |
| seg_hi | output | 4 | Upper segment half for the scanned digit |
| seg_lo | output | 4 | Lower segment half for the scanned digit |
| busy | output | 1 | High while a clear sweep is running |

## Verification
The assertions check four things on every cycle: the scan position is held or incremented exactly at digit ticks, the guard interval and the active blanking bits force the blank code, the decoded form is one-hot, and `busy` follows a clear command and never outlasts NDIG*DWELL cycles. The bench scenarios cover what depends on stored contents and command history. These are the data landing at the latched address, the half-byte write protection, ignored command kinds, the mode-field encoding, the dropping of writes during a clear, and the display memory being blank once the sweep ends.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [2:0] {
    OP_MODE  = 3'b000,
    OP_ADDR  = 3'b100,
    OP_GUARD = 3'b101,
    OP_WIPE  = 3'b110
  } disp_op_e;

  typedef struct packed {
    logic inh_hi;
    logic inh_lo;
    logic blk_hi;
    logic blk_lo;
  } half_ctl_t;
endpackage

// File: rtl/disp_scan_timer.sv
module disp_scan_timer #(
  parameter int NDIG  = 8,
  parameter int DWELL = 16,
  parameter int GUARD = 2,
  localparam int POS_W = $clog2(NDIG),
  localparam int DIV_W = $clog2(DWELL)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] scan_pos,
  output logic             digit_tick,
  output logic             guard_on
);
  logic [DIV_W-1:0] div_q;

  assign digit_tick = (div_q == DIV_W'(DWELL - 1));
  assign guard_on   = (div_q < DIV_W'(GUARD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      scan_pos <= '0;
    end else if (digit_tick) begin
      div_q    <= '0;
      scan_pos <= (scan_pos == POS_W'(NDIG - 1)) ? '0 : scan_pos + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/disp_cmd_dec.sv
module disp_cmd_dec
  import disp_pkg::*;
#(
  parameter int NDIG = 8,
  localparam int POS_W = $clog2(NDIG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             host_cmd,
  input  logic [7:0]       host_byte,
  output logic             decoded_mode,
  output logic [POS_W-1:0] wr_addr,
  output half_ctl_t        half_ctl,
  output logic             wipe_start,
  output logic             data_we
);
  logic     cmd_we;
  disp_op_e op;

  assign cmd_we     = host_we & host_cmd;
  assign op         = disp_op_e'(host_byte[7:5]);
  assign wipe_start = cmd_we && (op == OP_WIPE);
  assign data_we    = host_we & ~host_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decoded_mode <= 1'b0;
      wr_addr      <= '0;
      half_ctl     <= '0;
    end else if (cmd_we) begin
      case (op)
        OP_MODE:  decoded_mode <= (host_byte[4:3] != 2'b00);
        OP_ADDR:  wr_addr      <= host_byte[POS_W-1:0];
        OP_GUARD: half_ctl     <= half_ctl_t'(host_byte[3:0]);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/disp_ram.sv
module disp_ram
  import disp_pkg::*;
#(
  parameter int         NDIG  = 8,
  parameter logic [3:0] BLANK = 4'h0,
  localparam int POS_W = $clog2(NDIG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] scan_pos,
  input  logic             digit_tick,
  input  logic             wipe_start,
  input  logic             data_we,
  input  logic [POS_W-1:0] wr_addr,
  input  logic [7:0]       wr_byte,
  input  half_ctl_t        half_ctl,
  output logic [7:0]       rd_byte,
  output logic             busy
);
  logic [7:0]     mem [NDIG];
  logic [POS_W:0] sweep_q;
  logic           host_wr;

  assign host_wr = data_we & ~busy;
  assign rd_byte = mem[scan_pos];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sweep_q <= '0;
    end else if (wipe_start) begin
      busy    <= 1'b1;
      sweep_q <= '0;
    end else if (busy && digit_tick) begin
      if (sweep_q == (POS_W+1)'(NDIG - 1)) busy <= 1'b0;
      sweep_q <= sweep_q + 1'b1;
    end
  end

  for (genvar d = 0; d < NDIG; d++) begin : g_digit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem[d] <= {BLANK, BLANK};
      end else if (busy) begin
        if (scan_pos == POS_W'(d)) mem[d] <= {BLANK, BLANK};
      end else if (host_wr && wr_addr == POS_W'(d)) begin
        if (!half_ctl.inh_hi) mem[d][7:4] <= wr_byte[7:4];
        if (!half_ctl.inh_lo) mem[d][3:0] <= wr_byte[3:0];
      end
    end
  end
endmodule

// File: rtl/disp_refresh_ctrl.sv
module disp_refresh_ctrl
  import disp_pkg::*;
#(
  parameter int         NDIG  = 8,
  parameter int         DWELL = 16,
  parameter int         GUARD = 2,
  parameter logic [3:0] BLANK = 4'h0,
  localparam int POS_W = $clog2(NDIG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic            host_cmd,
  input  logic [7:0]      host_byte,
  output logic [NDIG-1:0] scan_o,
  output logic [3:0]      seg_hi,
  output logic [3:0]      seg_lo,
  output logic            busy
);
  logic [POS_W-1:0] scan_pos;
  logic             digit_tick;
  logic             guard_on;
  logic             decoded_mode;
  logic [POS_W-1:0] wr_addr;
  half_ctl_t        half_ctl;
  logic             wipe_start;
  logic             data_we;
  logic [7:0]       rd_byte;

  function automatic logic [NDIG-1:0] scan_code(input logic [POS_W-1:0] pos,
                                                input logic dec);
    return dec ? (NDIG'(1) << pos) : NDIG'(pos);
  endfunction

  function automatic logic [3:0] half_out(input logic [3:0] nib,
                                          input logic force_blank);
    return force_blank ? BLANK : nib;
  endfunction

  disp_scan_timer #(.NDIG(NDIG), .DWELL(DWELL), .GUARD(GUARD)) u_timer (
    .clk(clk), .rst_n(rst_n), .scan_pos(scan_pos),
    .digit_tick(digit_tick), .guard_on(guard_on)
  );

  disp_cmd_dec #(.NDIG(NDIG)) u_dec (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_cmd(host_cmd),
    .host_byte(host_byte), .decoded_mode(decoded_mode), .wr_addr(wr_addr),
    .half_ctl(half_ctl), .wipe_start(wipe_start), .data_we(data_we)
  );

  disp_ram #(.NDIG(NDIG), .BLANK(BLANK)) u_ram (
    .clk(clk), .rst_n(rst_n), .scan_pos(scan_pos), .digit_tick(digit_tick),
    .wipe_start(wipe_start), .data_we(data_we), .wr_addr(wr_addr),
    .wr_byte(host_byte), .half_ctl(half_ctl), .rd_byte(rd_byte), .busy(busy)
  );

  assign scan_o = scan_code(scan_pos, decoded_mode);
  assign seg_hi = half_out(rd_byte[7:4], guard_on | half_ctl.blk_hi);
  assign seg_lo = half_out(rd_byte[3:0], guard_on | half_ctl.blk_lo);
endmodule

// File: rtl/disp_refresh_chk.sv
module disp_refresh_chk #(
  parameter int         NDIG  = 8,
  parameter int         DWELL = 16,
  parameter logic [3:0] BLANK = 4'h0,
  localparam int POS_W = $clog2(NDIG),
  localparam int CNT_W = $clog2(NDIG * DWELL + 2) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [POS_W-1:0] scan_pos,
  input logic             digit_tick,
  input logic             guard_on,
  input logic             decoded_mode,
  input logic             blk_hi,
  input logic             blk_lo,
  input logic             wipe_start,
  input logic [NDIG-1:0]  scan_o,
  input logic [3:0]       seg_hi,
  input logic [3:0]       seg_lo,
  input logic             busy
);
  logic [CNT_W-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !digit_tick |=> $stable(scan_pos));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    digit_tick |=> scan_pos == ((($past(scan_pos) == POS_W'(NDIG - 1))) ? '0 : $past(scan_pos) + 1'b1));
  a_r8_guard_blank: assert property (@(posedge clk) disable iff (!rst_n)
    guard_on |-> (seg_hi == BLANK && seg_lo == BLANK));
  a_r6_blank_hi: assert property (@(posedge clk) disable iff (!rst_n)
    blk_hi |-> seg_hi == BLANK);
  a_r6_blank_lo: assert property (@(posedge clk) disable iff (!rst_n)
    blk_lo |-> seg_lo == BLANK);
  a_r3_decoded_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    decoded_mode |-> $countones(scan_o) == 1);
  a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_start |=> busy);
  a_r9_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= CNT_W'(NDIG * DWELL));
endmodule

bind disp_refresh_ctrl disp_refresh_chk #(.NDIG(NDIG), .DWELL(DWELL), .BLANK(BLANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_pos(scan_pos), .digit_tick(digit_tick),
  .guard_on(guard_on), .decoded_mode(decoded_mode), .blk_hi(half_ctl.blk_hi),
  .blk_lo(half_ctl.blk_lo), .wipe_start(wipe_start), .scan_o(scan_o),
  .seg_hi(seg_hi), .seg_lo(seg_lo), .busy(busy)
);

// File: tb/tb_disp_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_disp_refresh_ctrl;
  localparam int NDIG = 8, DWELL = 16, GUARD = 2;
  localparam logic [3:0] BLANK = 4'h0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0, host_cmd = 1'b0;
  logic [7:0] host_byte = '0;
  logic [NDIG-1:0] scan_o;
  logic [3:0] seg_hi, seg_lo;
  logic busy;
  int compared = 0, mismatched = 0, edges = 0;

  always #2 clk = ~clk;

  disp_refresh_ctrl #(.NDIG(NDIG), .DWELL(DWELL), .GUARD(GUARD), .BLANK(BLANK)) dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_cmd(host_cmd),
    .host_byte(host_byte), .scan_o(scan_o), .seg_hi(seg_hi), .seg_lo(seg_lo),
    .busy(busy)
  );

  always @(posedge clk) edges <= rst_n ? edges + 1 : 0;

  // {address, data}
  localparam logic [10:0] VEC [8] = '{
    {3'd3, 8'h78}, {3'd0, 8'h12}, {3'd6, 8'hDE}, {3'd1, 8'h34},
    {3'd7, 8'h21}, {3'd2, 8'h56}, {3'd5, 8'hBC}, {3'd4, 8'h9A}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic is_cmd, input logic [7:0] b);
    @(negedge clk);
    host_we = 1'b1; host_cmd = is_cmd; host_byte = b;
    @(negedge clk);
    host_we = 1'b0; host_cmd = 1'b0; host_byte = '0;
  endtask

  task automatic wait_slot(input int pos, input int phase);
    do @(negedge clk);
    while (!(((edges / DWELL) % NDIG) == pos && (edges % DWELL) == phase));
  endtask

  task automatic check_digit(input string req, input int pos, input logic [7:0] exp);
    wait_slot(pos, GUARD);
    check(req, {seg_hi, seg_lo}, exp);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 scan", scan_o, 0);
    check("R1 seg", {seg_hi, seg_lo}, {BLANK, BLANK});
    check("R1 busy", busy, 0);
    rst_n = 1'b1;
    // R2 stepping and wrap
    wait_slot(0, DWELL - 1); check("R2 last cycle pos0", scan_o, 0);
    wait_slot(1, 0);         check("R2 step to 1", scan_o, 1);
    wait_slot(7, DWELL - 1); check("R2 pos7", scan_o, 7);
    wait_slot(0, 0);         check("R2 wrap to 0", scan_o, 0);
    // R1 memory blank after reset
    check_digit("R1 ram blank", 4, {BLANK, BLANK});
    // R5 table of writes, R10 scan unaffected
    foreach (VEC[i]) begin
      send(1'b1, {3'b100, 2'b00, VEC[i][10:8]});
      send(1'b0, VEC[i][7:0]);
    end
    check("R10 scan tracks", scan_o, NDIG'((edges / DWELL) % NDIG));
    foreach (VEC[i]) check_digit("R5 digit data", int'(VEC[i][10:8]), VEC[i][7:0]);
    // R8 guard interval
    wait_slot(3, 0); check("R8 guard first", {seg_hi, seg_lo}, {BLANK, BLANK});
    wait_slot(3, GUARD - 1); check("R8 guard last", {seg_hi, seg_lo}, {BLANK, BLANK});
    // R6 blanking
    send(1'b1, 8'hA1); check_digit("R6 blank lo", 3, {4'h7, BLANK});
    send(1'b1, 8'hA2); check_digit("R6 blank hi", 3, {BLANK, 4'h8});
    send(1'b1, 8'hA0); check_digit("R6 restored", 3, 8'h78);
    // R7 write inhibit
    send(1'b1, 8'hA4); send(1'b1, 8'h82); send(1'b0, 8'hFF);
    check_digit("R7 inhibit lo", 2, 8'hF6);
    send(1'b1, 8'hA8); send(1'b0, 8'h11);
    check_digit("R7 inhibit hi", 2, 8'hF1);
    send(1'b1, 8'hA0);
    // R4 ignored kinds
    send(1'b1, 8'h3F); send(1'b1, 8'hE5); send(1'b1, 8'h47); send(1'b1, 8'h60);
    check_digit("R4 ignored data", 0, 8'h12);
    check_digit("R4 ignored mode", 5, 8'hBC);
    check("R4 still encoded", scan_o, 5);
    // R3 mode field
    send(1'b1, 8'h08); wait_slot(6, 4); check("R3 decoded 01", scan_o, 8'h40);
    send(1'b1, 8'h07); wait_slot(2, 4); check("R3 encoded 00", scan_o, 2);
    send(1'b1, 8'h10); wait_slot(7, 4); check("R3 decoded 10", scan_o, 8'h80);
    send(1'b1, 8'h00); wait_slot(1, 4); check("R3 encoded back", scan_o, 1);
    // R9 clear
    send(1'b1, 8'hC0);
    check("R9 busy rises", busy, 1);
    send(1'b1, 8'h85); send(1'b0, 8'h33);
    begin
      int n = 2;
      while (busy && n < NDIG * DWELL + 4) begin @(negedge clk); n++; end
      check("R9 busy falls in time", (n <= NDIG * DWELL) ? 1 : 0, 1);
    end
    for (int p = 0; p < NDIG; p++) check_digit("R9 ram wiped", p, {BLANK, BLANK});
    send(1'b0, 8'h4D); check_digit("R9 writes resume", 5, 8'h4D);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule